// File: doc/BRIEF.md
# Tag-Broadcast Issue Window

This block is the scheduling window of an out-of-order core. After renaming, an instruction enters the window carrying an opcode, a destination tag and two source operands. Each source either arrives with its value already known, or names the tag of the instruction that will produce that value. The window holds the instruction until both of its sources are known.

A single result bus carries at most one produced tag and its value per cycle. Every waiting source compares its own tag with the tag on the bus. On a match it takes the value from the bus and becomes ready. Sources never poll a register scoreboard.

Each cycle the oldest resident instruction with both sources ready is offered to a functional unit through a valid/ready handshake. An entry leaves the window in the cycle the unit accepts it. This lets a younger independent instruction leave ahead of an older one that is still waiting. A full flag tells the rename stage to hold back new instructions.

Top module: `issue_window`

## Requirements
- R1: After reset the window is empty: `issueValid` is 0 and `windowFull` is 0.
- R2: When `allocValid` is 1 and `windowFull` is 0 at a clock edge, the instruction enters the window at that edge. If both of its sources are marked ready, it is offered on the issue port after that edge, with its opcode, destination tag and both source values.
- R3: A resident source that is not ready becomes ready at the edge where `bcastValid` is 1 and `bcastTag` equals its tag. It holds `bcastVal` from then on.
- R4: A broadcast has no effect on a source when `bcastValid` is 0, when the tag differs, or when the source is already ready. Such a source keeps its state and value.
- R5: An entering source that is not ready is also compared with the broadcast in the same cycle. On a match it enters the window already ready, holding `bcastVal`.
- R6: Only an entry with both sources ready is offered. A younger ready entry is offered while an older entry still waits.
- R7: Among ready entries, the one that entered earliest is offered. This holds regardless of which storage slot each entry occupies.
- R8: While `issueValid` is 1 and `issueReady` is 0, the next cycle offers the same instruction with the same fields. This holds even if an older entry wakes up in the meantime.
- R9: `windowFull` is 1 exactly when all 8 entries are occupied. An allocation attempted while `windowFull` is 1 is dropped.
- R10: An entry is freed at the edge where `issueValid` and `issueReady` are both 1. The freed slot clears `windowFull` and can be reused by a later allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| allocValid | input | 1 | Request to insert a renamed instruction |
| allocOp | input | OP_W | Opcode of the inserted instruction |
| allocSrcARdy | input | 1 | Source A value already known |
| allocSrcATag | input | TAG_W | Producer tag of source A |
| allocSrcAVal | input | DATA_W | Value of source A when ready |
| allocSrcBRdy | input | 1 | Source B value already known |
| allocSrcBTag | input | TAG_W | Producer tag of source B |
| allocSrcBVal | input | DATA_W | Value of source B when ready |
| allocDstTag | input | TAG_W | Tag the instruction will broadcast |
| windowFull | output | 1 | All entries occupied; allocation is dropped |
| bcastValid | input | 1 | Result bus carries a result this cycle |
| bcastTag | input | TAG_W | Tag of the produced result |
| bcastVal | input | DATA_W | Value of the produced result |
| issueValid | output | 1 | An instruction is offered to the functional unit |
| issueReady | input | 1 | Functional unit accepts the offered instruction |
| issueOp | output | OP_W | Opcode of the offered instruction |
| issueSrcA | output | DATA_W | Source A value of the offered instruction |
| issueSrcB | output | DATA_W | Source B value of the offered instruction |
| issueDstTag | output | TAG_W | Destination tag of the offered instruction |

## Verification
The assertions rely on three properties of the inputs. The rename stage gives every in-flight producer a distinct tag. No tag is broadcast twice while a consumer still waits on it. `allocValid` is only raised with meaningful fields.

Under these assumptions, the ranking check treats ages as a strict order among resident entries. The hold check treats an offered entry as unable to disappear, because ready bits only rise.

The stimulus uses tags that are unique per scenario, and drives a foreign tag only in the deliberate no-match cases. It drains the window completely between scenarios, so that each scenario starts from a known empty state.

// File: rtl/iw_pkg.sv
package iw_pkg;
  localparam int IW_ENTRIES = 8;
  localparam int IW_IDX_W   = $clog2(IW_ENTRIES);

  // strobes from control to datapath
  typedef struct packed {
    logic [IW_ENTRIES-1:0] wrOneHot;   // slot written this cycle
    logic [IW_ENTRIES-1:0] selOneHot;  // slot offered on the issue port
  } iw_strobe_t;
endpackage

// File: rtl/iw_operand.sv
module iw_operand #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              loadRdy,
  input  logic [TAG_W-1:0]  loadTag,
  input  logic [DATA_W-1:0] loadVal,
  input  logic              bcastValid,
  input  logic [TAG_W-1:0]  bcastTag,
  input  logic [DATA_W-1:0] bcastVal,
  output logic              rdy,
  output logic [DATA_W-1:0] val
);
  logic              rdyQ;
  logic [TAG_W-1:0]  tagQ;
  logic [DATA_W-1:0] valQ;
  logic              hitLoad;
  logic              hitHeld;

  assign hitLoad = bcastValid && (bcastTag == loadTag);
  assign hitHeld = bcastValid && !rdyQ && (bcastTag == tagQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdyQ <= 1'b0;
      tagQ <= '0;
      valQ <= '0;
    end else if (load) begin
      tagQ <= loadTag;
      if (loadRdy) begin
        rdyQ <= 1'b1;
        valQ <= loadVal;
      end else if (hitLoad) begin
        rdyQ <= 1'b1;
        valQ <= bcastVal;
      end else begin
        rdyQ <= 1'b0;
      end
    end else if (hitHeld) begin
      rdyQ <= 1'b1;
      valQ <= bcastVal;
    end
  end

  assign rdy = rdyQ;
  assign val = valQ;

  // R3: a waiting source catches a matching broadcast
  a_r3_wakeup_capture: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !rdyQ && bcastValid && bcastTag == tagQ)
      |=> (rdyQ && valQ == $past(bcastVal)));

  // R4: a ready source is left alone by any broadcast
  a_r4_ready_kept: assert property (@(posedge clk) disable iff (!rstN)
    (!load && rdyQ) |=> (rdyQ && $stable(valQ)));

  // R4: a waiting source without a matching broadcast stays waiting
  a_r4_no_false_wake: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !rdyQ && !(bcastValid && bcastTag == tagQ)) |=> !rdyQ);

  // R5: broadcast seen in the allocation cycle is not lost
  a_r5_alloc_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (load && !loadRdy && bcastValid && bcastTag == loadTag)
      |=> (rdyQ && valQ == $past(bcastVal)));
endmodule

// File: rtl/iw_ctrl.sv
module iw_ctrl (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          allocValid,
  input  logic                          issueReady,
  input  logic [iw_pkg::IW_ENTRIES-1:0] readyVec,
  output iw_pkg::iw_strobe_t            strobe,
  output logic                          windowFull,
  output logic                          issueValid
);
  localparam int N     = iw_pkg::IW_ENTRIES;
  localparam int IDX_W = iw_pkg::IW_IDX_W;
  localparam int CNT_W = IDX_W + 1;

  logic [N-1:0]     validQ;
  logic [IDX_W-1:0] ageQ [N];      // 0 = oldest resident entry
  logic             holdQ;
  logic [N-1:0]     heldOneHot;

  logic [N-1:0]     candVec;
  logic [N-1:0]     winVec;
  logic [N-1:0]     freeSlot;
  logic [N-1:0]     selVec;
  logic [IDX_W-1:0] freeAge;
  logic [CNT_W-1:0] validCount;
  logic [CNT_W-1:0] newAge;
  logic             allocFire;
  logic             fire;

  assign windowFull = &validQ;
  assign allocFire  = allocValid && !windowFull;
  assign candVec    = validQ & readyVec;
  assign validCount = CNT_W'($countones(validQ));

  // oldest-first pick among ready entries
  always_comb begin
    for (int i = 0; i < N; i++) begin
      winVec[i] = candVec[i];
      for (int j = 0; j < N; j++) begin
        if (j != i && candVec[j] && (ageQ[j] < ageQ[i])) winVec[i] = 1'b0;
      end
    end
  end

  // lowest free slot
  always_comb begin
    logic found;
    found    = 1'b0;
    freeSlot = '0;
    for (int i = 0; i < N; i++) begin
      if (!validQ[i] && !found) begin
        freeSlot[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  assign selVec     = holdQ ? heldOneHot : winVec;
  assign issueValid = |selVec;
  assign fire       = issueValid && issueReady;

  always_comb begin
    freeAge = '0;
    for (int i = 0; i < N; i++) begin
      if (selVec[i]) freeAge = freeAge | ageQ[i];
    end
  end

  assign newAge = validCount - CNT_W'(fire);

  assign strobe.wrOneHot  = allocFire ? freeSlot : '0;
  assign strobe.selOneHot = selVec;

  generate
    for (genvar g = 0; g < N; g++) begin : g_slot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          validQ[g] <= 1'b0;
          ageQ[g]   <= '0;
        end else if (strobe.wrOneHot[g]) begin
          validQ[g] <= 1'b1;
          ageQ[g]   <= newAge[IDX_W-1:0];
        end else if (fire && selVec[g]) begin
          validQ[g] <= 1'b0;
        end else if (fire && validQ[g] && (ageQ[g] > freeAge)) begin
          ageQ[g] <= ageQ[g] - 1'b1;
        end
      end

      // R7: ages of resident entries stay a compact ranking
      a_r7_age_rank: assert property (@(posedge clk) disable iff (!rstN)
        validQ[g] |-> (CNT_W'(ageQ[g]) < validCount));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ      <= 1'b0;
      heldOneHot <= '0;
    end else begin
      holdQ      <= issueValid && !issueReady;
      heldOneHot <= selVec;
    end
  end

  // R6: only resident entries with both sources ready are offered
  a_r6_offer_ready: assert property (@(posedge clk) disable iff (!rstN)
    ((selVec & ~candVec) == '0) && $onehot0(selVec));

  // R8: a refused offer is repeated unchanged
  a_r8_hold_offer: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !issueReady) |=> (issueValid && selVec == $past(selVec)));

  // R9: no entry is added while the window is full
  a_r9_full_drops: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && windowFull && !fire) |=> $stable(validQ));

  // R10: an accepted entry leaves the window
  a_r10_fire_frees: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> ($countones(validQ) <= $countones($past(validQ))));
endmodule

// File: rtl/iw_data.sv
module iw_data #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32,
  parameter int OP_W   = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  iw_pkg::iw_strobe_t            strobe,
  input  logic [OP_W-1:0]               allocOp,
  input  logic                          allocSrcARdy,
  input  logic [TAG_W-1:0]              allocSrcATag,
  input  logic [DATA_W-1:0]             allocSrcAVal,
  input  logic                          allocSrcBRdy,
  input  logic [TAG_W-1:0]              allocSrcBTag,
  input  logic [DATA_W-1:0]             allocSrcBVal,
  input  logic [TAG_W-1:0]              allocDstTag,
  input  logic                          bcastValid,
  input  logic [TAG_W-1:0]              bcastTag,
  input  logic [DATA_W-1:0]             bcastVal,
  output logic [iw_pkg::IW_ENTRIES-1:0] readyVec,
  output logic [OP_W-1:0]               issueOp,
  output logic [DATA_W-1:0]             issueSrcA,
  output logic [DATA_W-1:0]             issueSrcB,
  output logic [TAG_W-1:0]              issueDstTag
);
  localparam int N = iw_pkg::IW_ENTRIES;

  logic [OP_W-1:0]   opQ  [N];
  logic [TAG_W-1:0]  dstQ [N];
  logic [N-1:0]      rdyA;
  logic [N-1:0]      rdyB;
  logic [DATA_W-1:0] valA [N];
  logic [DATA_W-1:0] valB [N];

  generate
    for (genvar g = 0; g < N; g++) begin : g_entry
      iw_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) i_srcA (
        .clk(clk), .rstN(rstN), .load(strobe.wrOneHot[g]),
        .loadRdy(allocSrcARdy), .loadTag(allocSrcATag), .loadVal(allocSrcAVal),
        .bcastValid(bcastValid), .bcastTag(bcastTag), .bcastVal(bcastVal),
        .rdy(rdyA[g]), .val(valA[g]));

      iw_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) i_srcB (
        .clk(clk), .rstN(rstN), .load(strobe.wrOneHot[g]),
        .loadRdy(allocSrcBRdy), .loadTag(allocSrcBTag), .loadVal(allocSrcBVal),
        .bcastValid(bcastValid), .bcastTag(bcastTag), .bcastVal(bcastVal),
        .rdy(rdyB[g]), .val(valB[g]));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          opQ[g]  <= '0;
          dstQ[g] <= '0;
        end else if (strobe.wrOneHot[g]) begin
          opQ[g]  <= allocOp;
          dstQ[g] <= allocDstTag;
        end
      end

      // R2: a written entry holds the allocated fields
      a_r2_fields_written: assert property (@(posedge clk) disable iff (!rstN)
        strobe.wrOneHot[g] |=> (opQ[g] == $past(allocOp) && dstQ[g] == $past(allocDstTag)));
    end
  endgenerate

  assign readyVec = rdyA & rdyB;

  // AND-OR issue mux on the one-hot select
  always_comb begin
    issueOp     = '0;
    issueSrcA   = '0;
    issueSrcB   = '0;
    issueDstTag = '0;
    for (int i = 0; i < N; i++) begin
      if (strobe.selOneHot[i]) begin
        issueOp     = issueOp     | opQ[i];
        issueSrcA   = issueSrcA   | valA[i];
        issueSrcB   = issueSrcB   | valB[i];
        issueDstTag = issueDstTag | dstQ[i];
      end
    end
  end
endmodule

// File: rtl/issue_window.sv
module issue_window #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32,
  parameter int OP_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [OP_W-1:0]   allocOp,
  input  logic              allocSrcARdy,
  input  logic [TAG_W-1:0]  allocSrcATag,
  input  logic [DATA_W-1:0] allocSrcAVal,
  input  logic              allocSrcBRdy,
  input  logic [TAG_W-1:0]  allocSrcBTag,
  input  logic [DATA_W-1:0] allocSrcBVal,
  input  logic [TAG_W-1:0]  allocDstTag,
  output logic              windowFull,
  input  logic              bcastValid,
  input  logic [TAG_W-1:0]  bcastTag,
  input  logic [DATA_W-1:0] bcastVal,
  output logic              issueValid,
  input  logic              issueReady,
  output logic [OP_W-1:0]   issueOp,
  output logic [DATA_W-1:0] issueSrcA,
  output logic [DATA_W-1:0] issueSrcB,
  output logic [TAG_W-1:0]  issueDstTag
);
  iw_pkg::iw_strobe_t             strobe;
  logic [iw_pkg::IW_ENTRIES-1:0]  readyVec;

  iw_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .issueReady(issueReady),
    .readyVec(readyVec), .strobe(strobe), .windowFull(windowFull),
    .issueValid(issueValid));

  iw_data #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .allocOp(allocOp),
    .allocSrcARdy(allocSrcARdy), .allocSrcATag(allocSrcATag), .allocSrcAVal(allocSrcAVal),
    .allocSrcBRdy(allocSrcBRdy), .allocSrcBTag(allocSrcBTag), .allocSrcBVal(allocSrcBVal),
    .allocDstTag(allocDstTag),
    .bcastValid(bcastValid), .bcastTag(bcastTag), .bcastVal(bcastVal),
    .readyVec(readyVec), .issueOp(issueOp), .issueSrcA(issueSrcA),
    .issueSrcB(issueSrcB), .issueDstTag(issueDstTag));
endmodule

// File: tb/test_issue_window.sv
`timescale 1ns/1ps
module test_issue_window;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        allocValid = 1'b0;
  logic [5:0]  allocOp = '0;
  logic        allocSrcARdy = 1'b0;
  logic [3:0]  allocSrcATag = '0;
  logic [31:0] allocSrcAVal = '0;
  logic        allocSrcBRdy = 1'b0;
  logic [3:0]  allocSrcBTag = '0;
  logic [31:0] allocSrcBVal = '0;
  logic [3:0]  allocDstTag = '0;
  logic        windowFull;
  logic        bcastValid = 1'b0;
  logic [3:0]  bcastTag = '0;
  logic [31:0] bcastVal = '0;
  logic        issueValid;
  logic        issueReady = 1'b0;
  logic [5:0]  issueOp;
  logic [31:0] issueSrcA;
  logic [31:0] issueSrcB;
  logic [3:0]  issueDstTag;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  issue_window i_issue_window (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocOp(allocOp),
    .allocSrcARdy(allocSrcARdy), .allocSrcATag(allocSrcATag), .allocSrcAVal(allocSrcAVal),
    .allocSrcBRdy(allocSrcBRdy), .allocSrcBTag(allocSrcBTag), .allocSrcBVal(allocSrcBVal),
    .allocDstTag(allocDstTag), .windowFull(windowFull),
    .bcastValid(bcastValid), .bcastTag(bcastTag), .bcastVal(bcastVal),
    .issueValid(issueValid), .issueReady(issueReady), .issueOp(issueOp),
    .issueSrcA(issueSrcA), .issueSrcB(issueSrcB), .issueDstTag(issueDstTag));

  typedef struct packed {
    logic        aV;   logic [5:0]  op;
    logic        aR;   logic [3:0]  aT;   logic [31:0] aVal;
    logic        bR;   logic [3:0]  bT;   logic [31:0] bVal;
    logic [3:0]  dst;
    logic        cV;   logic [3:0]  cT;   logic [31:0] cVal;
    logic        iRdy;
    logic        eV;   logic [5:0]  eOp;  logic [3:0]  eDst;
    logic [31:0] eA;   logic [31:0] eB;   logic        eFull;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    // R2 waiting entry enters, nothing offered
    '{1'b1,6'd1, 1'b0,4'd3,32'd0,  1'b1,4'd0,32'd10, 4'd1, 1'b0,4'd0,32'd0,  1'b1, 1'b0,6'd0,4'd0,32'd0,32'd0,1'b0},
    // R6 younger ready entry offered ahead of older waiting one
    '{1'b1,6'd2, 1'b1,4'd0,32'd20, 1'b1,4'd0,32'd21, 4'd2, 1'b0,4'd0,32'd0,  1'b0, 1'b1,6'd2,4'd2,32'd20,32'd21,1'b0},
    // R8 older entry wakes while offer refused: offer unchanged
    '{1'b0,6'd0, 1'b0,4'd0,32'd0,  1'b0,4'd0,32'd0,  4'd0, 1'b1,4'd3,32'd33, 1'b0, 1'b1,6'd2,4'd2,32'd20,32'd21,1'b0},
    // R3/R10 accepted; woken entry now offered with captured value
    '{1'b0,6'd0, 1'b0,4'd0,32'd0,  1'b0,4'd0,32'd0,  4'd0, 1'b0,4'd0,32'd0,  1'b1, 1'b1,6'd1,4'd1,32'd33,32'd10,1'b0},
    '{1'b0,6'd0, 1'b0,4'd0,32'd0,  1'b0,4'd0,32'd0,  4'd0, 1'b0,4'd0,32'd0,  1'b1, 1'b0,6'd0,4'd0,32'd0,32'd0,1'b0},
    // R5 source A caught in allocation cycle, B still waiting
    '{1'b1,6'd5, 1'b0,4'd7,32'd0,  1'b0,4'd8,32'd0,  4'd5, 1'b1,4'd7,32'd70, 1'b1, 1'b0,6'd0,4'd0,32'd0,32'd0,1'b0},
    // R4 foreign tag
    '{1'b0,6'd0, 1'b0,4'd0,32'd0,  1'b0,4'd0,32'd0,  4'd0, 1'b1,4'd9,32'd99, 1'b1, 1'b0,6'd0,4'd0,32'd0,32'd0,1'b0},
    // R4 right tag but bus not valid
    '{1'b0,6'd0, 1'b0,4'd0,32'd0,  1'b0,4'd0,32'd0,  4'd0, 1'b0,4'd8,32'd1,  1'b1, 1'b0,6'd0,4'd0,32'd0,32'd0,1'b0},
    // R3 wakes B; A keeps value caught earlier
    '{1'b0,6'd0, 1'b0,4'd0,32'd0,  1'b0,4'd0,32'd0,  4'd0, 1'b1,4'd8,32'd80, 1'b1, 1'b1,6'd5,4'd5,32'd70,32'd80,1'b0},
    '{1'b0,6'd0, 1'b0,4'd0,32'd0,  1'b0,4'd0,32'd0,  4'd0, 1'b1,4'd8,32'd5,  1'b1, 1'b0,6'd0,4'd0,32'd0,32'd0,1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    allocValid = 1'b0;
    bcastValid = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic alloc(input logic [5:0] op, input logic aR, input logic [3:0] aT,
                       input logic [31:0] aVal, input logic bR, input logic [3:0] bT,
                       input logic [31:0] bVal, input logic [3:0] dst);
    allocValid = 1'b1; allocOp = op;
    allocSrcARdy = aR; allocSrcATag = aT; allocSrcAVal = aVal;
    allocSrcBRdy = bR; allocSrcBTag = bT; allocSrcBVal = bVal;
    allocDstTag = dst;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 issueValid", 32'(issueValid), 32'd0);
    check("R1 windowFull", 32'(windowFull), 32'd0);
    rstN = 1'b1;
    step();

    // vector table
    for (int v = 0; v < NV; v++) begin
      allocValid = VECS[v].aV; allocOp = VECS[v].op;
      allocSrcARdy = VECS[v].aR; allocSrcATag = VECS[v].aT; allocSrcAVal = VECS[v].aVal;
      allocSrcBRdy = VECS[v].bR; allocSrcBTag = VECS[v].bT; allocSrcBVal = VECS[v].bVal;
      allocDstTag = VECS[v].dst;
      bcastValid = VECS[v].cV; bcastTag = VECS[v].cT; bcastVal = VECS[v].cVal;
      issueReady = VECS[v].iRdy;
      step();
      check($sformatf("R2-R8 row%0d issueValid", v), 32'(issueValid), 32'(VECS[v].eV));
      check($sformatf("R9 row%0d windowFull", v), 32'(windowFull), 32'(VECS[v].eFull));
      if (VECS[v].eV) begin
        check($sformatf("R2 row%0d op", v), 32'(issueOp), 32'(VECS[v].eOp));
        check($sformatf("R2 row%0d dst", v), 32'(issueDstTag), 32'(VECS[v].eDst));
        check($sformatf("R3 row%0d srcA", v), issueSrcA, VECS[v].eA);
        check($sformatf("R3 row%0d srcB", v), issueSrcB, VECS[v].eB);
      end
    end
    idle();

    // R7: age order differs from slot order
    issueReady = 1'b1;
    alloc(6'd1, 1'b0, 4'd5, 32'd0, 1'b1, 4'd0, 32'd100, 4'd1); step();
    alloc(6'd2, 1'b1, 4'd0, 32'd1,  1'b1, 4'd0, 32'd2,   4'd2); step();
    check("R2 ready entry offered", 32'(issueDstTag), 32'd2);
    alloc(6'd3, 1'b0, 4'd5, 32'd0, 1'b1, 4'd0, 32'd300, 4'd3); step();
    check("R10 accepted entry gone", 32'(issueValid), 32'd0);
    alloc(6'd4, 1'b0, 4'd5, 32'd0, 1'b1, 4'd0, 32'd400, 4'd4); step();
    allocValid = 1'b0;
    bcastValid = 1'b1; bcastTag = 4'd5; bcastVal = 32'd55; step();
    bcastValid = 1'b0;
    check("R7 oldest first", 32'(issueDstTag), 32'd1);
    check("R7 value", issueSrcA, 32'd55);
    step();
    check("R7 second oldest", 32'(issueDstTag), 32'd3);
    step();
    check("R7 youngest last", 32'(issueDstTag), 32'd4);
    check("R7 youngest srcB", issueSrcB, 32'd400);
    step();
    check("R10 drained", 32'(issueValid), 32'd0);

    // R9/R10: fill, drop while full, drain
    issueReady = 1'b0;
    for (int k = 0; k < 8; k++) begin
      alloc(6'(k), 1'b0, 4'd15, 32'd0, 1'b1, 4'd0, 32'(k), 4'(k));
      step();
      check($sformatf("R9 full after %0d", k + 1), 32'(windowFull), 32'(k == 7));
    end
    alloc(6'd9, 1'b1, 4'd0, 32'd9, 1'b1, 4'd0, 32'd9, 4'd9); step();
    check("R9 dropped alloc not offered", 32'(issueValid), 32'd0);
    check("R9 still full", 32'(windowFull), 32'd1);
    allocValid = 1'b0;
    bcastValid = 1'b1; bcastTag = 4'd15; bcastVal = 32'd150; step();
    bcastValid = 1'b0;
    issueReady = 1'b1;
    for (int k = 0; k < 8; k++) begin
      check($sformatf("R7 drain order %0d", k), 32'(issueDstTag), 32'(k));
      step();
      if (k == 0) check("R10 full clears on accept", 32'(windowFull), 32'd0);
    end
    check("R9 dropped alloc never entered", 32'(issueValid), 32'd0);

    // R10 slot reused
    alloc(6'd33, 1'b1, 4'd0, 32'd7, 1'b1, 4'd0, 32'd8, 4'd12); step();
    allocValid = 1'b0;
    check("R10 reuse dst", 32'(issueDstTag), 32'd12);
    check("R10 reuse op", 32'(issueOp), 32'd33);
    step();
    check("R10 reuse drained", 32'(issueValid), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule